// File: doc/BRIEF.md
# CAN Bus Wake-Up Pattern Detector

This block sits beside a CAN transceiver's low-power receiver and decides when a sleeping node has been asked to wake up from the bus. It samples a digital "bus is dominant" indication, synchronises it to the local clock and passes it through a digital stability filter. A state machine then looks for a dominant phase, then a recessive phase, then a second dominant phase, each lasting at least a set number of cycles, with the whole sequence finished inside a bounded window that opens when the first dominant phase begins.

While the pattern has not been seen, the receive-data output stays HIGH so that the host sees an idle bus. When the final dominant phase qualifies, the block emits a one-cycle wake pulse and from then on the receive-data output follows the filtered bus level while the node is still in standby. The pattern is abandoned without a wake when the mode input selects normal operation, when the window runs out, or when the undervoltage flag is raised. Leaving standby clears the woken state. Every time threshold is a parameter counted in clock cycles.

The state machine has five states. NORMAL is the state outside standby. HUNT waits for the first dominant phase. SEEK_REC waits for the qualifying recessive phase, and SEEK_DOM waits for the closing dominant phase. WOKEN is entered once the pattern completes. The transitions are these:
- NORMAL goes to HUNT when standby is selected.
- HUNT goes to SEEK_REC when the first dominant run reaches the minimum dominant length.
- SEEK_REC goes to SEEK_DOM when a recessive run reaches the minimum recessive length.
- SEEK_DOM goes to WOKEN when a dominant run reaches the minimum dominant length inside the window.
- SEEK_REC and SEEK_DOM return to HUNT when the window expires.
- HUNT, SEEK_REC and SEEK_DOM return to HUNT, with their counters cleared, when undervoltage is flagged.
- Any state goes to NORMAL when standby is released.

Top module: `can_wake_detect`

## Requirements
- R1: After reset, `rxd_o` is 1 and `wake_o` is 0.
- R2: A dominant phase of at least DOM_CYC cycles, then a recessive phase of at least REC_CYC cycles, then a dominant phase of at least DOM_CYC cycles, all in standby, produces exactly one `wake_o` pulse that is one cycle wide.
- R3: A dominant phase shorter than DOM_CYC does not open a pattern. A recessive phase shorter than REC_CYC does not advance it. Neither produces a wake.
- R4: After the first dominant phase qualifies, intervals that are shorter than the threshold of the level being sought (dominant, or recessive) are ignored. They restart only the run count of the current phase, not the pattern, so a qualifying phase that follows still completes the pattern.
- R5: The pattern completes only if the final dominant phase qualifies within WIN_CYC cycles, counted from the first cycle of the first qualifying dominant phase (filtered). If it does not, the detector returns to hunting and a full new pattern is needed.
- R6: Until a wake pulse has occurred, `rxd_o` stays 1 whatever the bus does.
- R7: Once woken, and while standby is held, `rxd_o` is the inverse of the filtered bus level: 0 for dominant and 1 for recessive. It lags the filtered level by one cycle.
- R8: A bus level that persists for fewer than FILT_CYC cycles after synchronisation does not reach the detector or `rxd_o`. The filtered level changes only after the synchronised input has differed from it for FILT_CYC consecutive cycles.
- R9: When `standby_i` is 0, the pattern in progress is dropped and `wake_o` stays 0 on the following cycle.
- R10: When `uv_i` is 1 during a pattern in progress, the pattern is dropped with no wake.
- R11: Leaving standby clears the woken state. While `standby_i` is 0, `rxd_o` is 1 one cycle later, and after standby is entered again a fresh full pattern is needed before the next wake.
- R12: `bus_dom_i` passes through a two-flop synchroniser before filtering. A clean input phase of at least FILT_CYC cycles therefore keeps its length through the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_dom_i | input | 1 | Bus level from the low-power receiver: 1 = dominant, 0 = recessive |
| standby_i | input | 1 | Mode select: 1 = standby, 0 = normal |
| uv_i | input | 1 | Supply undervoltage flag |
| rxd_o | output | 1 | Receive-data output: 1 = recessive or not yet woken |
| wake_o | output | 1 | One-cycle pulse when the wake pattern completes |

## Verification
The detector is driven with several kinds of bus traffic.
- Clean patterns check that a wake happens at all.
- Patterns whose first phase or recessive phase is one step short check that the length thresholds are in force.
- Patterns with ignorable short intervals in the second or third phase check that those intervals do not restart the pattern.
- A pair of patterns that finish exactly at the window limit and one cycle past it pins down the timeout boundary.
- Spikes shorter than the filter time, both before and after a wake, check that the filter hides them from the detector and from `rxd_o`.
- Standby release, undervoltage and re-entry into standby are applied partway through a pattern and after a wake, to show that each of them drops the pattern or clears the woken state as required.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
    typedef enum logic [2:0] {
        WK_NORMAL   = 3'd0,
        WK_HUNT     = 3'd1,
        WK_SEEK_REC = 3'd2,
        WK_SEEK_DOM = 3'd3,
        WK_WOKEN    = 3'd4
    } wk_state_t;
endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wkp_glitch_filter.sv
module wkp_glitch_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    generate
        if (FILT_CYC <= 1) begin : g_pass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) filt_o <= 1'b0;
                else        filt_o <= raw_i;
            end
        end else begin : g_count
            localparam int CW = $clog2(FILT_CYC + 1);
            logic [CW-1:0] diff_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    filt_o   <= 1'b0;
                    diff_cnt <= '0;
                end else if (raw_i == filt_o) begin
                    diff_cnt <= '0;
                end else if (diff_cnt == CW'(FILT_CYC - 1)) begin
                    filt_o   <= raw_i;
                    diff_cnt <= '0;
                end else begin
                    diff_cnt <= diff_cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wkp_seq.sv
module wkp_seq
    import wkp_pkg::*;
#(
    parameter int DOM_CYC = 50,
    parameter int REC_CYC = 50,
    parameter int WIN_CYC = 50000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fdom_i,
    input  logic      standby_i,
    input  logic      uv_i,
    output logic      rxd_o,
    output logic      wake_o,
    output wk_state_t state_o
);
    localparam int MAXPH = (DOM_CYC > REC_CYC) ? DOM_CYC : REC_CYC;
    localparam int RW    = $clog2(MAXPH + 1);
    localparam int WW    = $clog2(WIN_CYC + 1);

    wk_state_t     state, nxt;
    logic [RW-1:0] run_q, run_d;
    logic [WW-1:0] win_q, win_d;

    always_comb begin
        nxt   = state;
        run_d = run_q;
        win_d = win_q;
        unique case (state)
            WK_NORMAL: begin
                run_d = '0;
                win_d = '0;
                if (standby_i) nxt = WK_HUNT;
            end
            WK_HUNT: begin
                win_d = '0;
                if (!fdom_i) begin
                    run_d = '0;
                end else if (run_q == RW'(DOM_CYC - 1)) begin
                    nxt   = WK_SEEK_REC;
                    run_d = '0;
                    win_d = WW'(DOM_CYC);
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
            WK_SEEK_REC: begin
                win_d = win_q + 1'b1;
                if (fdom_i) begin
                    run_d = '0;
                end else if (run_q == RW'(REC_CYC - 1)) begin
                    nxt   = WK_SEEK_DOM;
                    run_d = '0;
                end else begin
                    run_d = run_q + 1'b1;
                end
                if (win_q == WW'(WIN_CYC - 1)) begin
                    nxt   = WK_HUNT;
                    run_d = '0;
                    win_d = '0;
                end
            end
            WK_SEEK_DOM: begin
                win_d = win_q + 1'b1;
                if (!fdom_i) begin
                    run_d = '0;
                end else if (run_q == RW'(DOM_CYC - 1)) begin
                    nxt   = WK_WOKEN;
                    run_d = '0;
                end else begin
                    run_d = run_q + 1'b1;
                end
                if (nxt != WK_WOKEN && win_q == WW'(WIN_CYC - 1)) begin
                    nxt   = WK_HUNT;
                    run_d = '0;
                    win_d = '0;
                end
            end
            WK_WOKEN: begin
                run_d = '0;
                win_d = '0;
            end
            default: begin
                nxt   = WK_NORMAL;
                run_d = '0;
                win_d = '0;
            end
        endcase

        if (!standby_i) begin
            nxt   = WK_NORMAL;
            run_d = '0;
            win_d = '0;
        end else if (uv_i && state != WK_WOKEN && state != WK_NORMAL) begin
            nxt   = WK_HUNT;
            run_d = '0;
            win_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WK_NORMAL;
            run_q <= '0;
            win_q <= '0;
        end else begin
            state <= nxt;
            run_q <= run_d;
            win_q <= win_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_o  <= 1'b1;
            wake_o <= 1'b0;
        end else begin
            wake_o <= (state != WK_WOKEN) && (nxt == WK_WOKEN);
            rxd_o  <= (nxt == WK_WOKEN) ? ~fdom_i : 1'b1;
        end
    end

    assign state_o = state;
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect
    import wkp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 8,
    parameter int DOM_CYC     = 50,
    parameter int REC_CYC     = 50,
    parameter int WIN_CYC     = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_dom_i,
    input  logic standby_i,
    input  logic uv_i,
    output logic rxd_o,
    output logic wake_o
);
    logic      sync_dom;
    logic      filt_dom;
    wk_state_t seq_state;

    wkp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_dom_i),
        .q     (sync_dom)
    );

    wkp_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sync_dom),
        .filt_o (filt_dom)
    );

    wkp_seq #(
        .DOM_CYC (DOM_CYC),
        .REC_CYC (REC_CYC),
        .WIN_CYC (WIN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fdom_i    (filt_dom),
        .standby_i (standby_i),
        .uv_i      (uv_i),
        .rxd_o     (rxd_o),
        .wake_o    (wake_o),
        .state_o   (seq_state)
    );
endmodule

// File: rtl/wkp_chk.sv
module wkp_chk
    import wkp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      standby_i,
    input logic      uv_i,
    input logic      rxd_o,
    input logic      wake_o,
    input logic      sync_dom,
    input logic      filt_dom,
    input wk_state_t state
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    a_r9_normal_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |=> !wake_o);

    a_r10_uv_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_i && state != WK_WOKEN) |=> !wake_o);

    a_r11_rxd_high_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |=> rxd_o);

    a_r7_rxd_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WK_WOKEN && standby_i) |=> (rxd_o == !$past(filt_dom)));

    a_r8_filter_settled: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_dom) |-> ($past(sync_dom) == filt_dom));

    a_r6_rxd_high_unwoken: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WK_WOKEN && !wake_o) |-> rxd_o);
endmodule

bind can_wake_detect wkp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .uv_i      (uv_i),
    .rxd_o     (rxd_o),
    .wake_o    (wake_o),
    .sync_dom  (sync_dom),
    .filt_dom  (filt_dom),
    .state     (seq_state)
);

// File: tb/can_wake_detect_tb.sv
module can_wake_detect_tb;
    localparam int FILT = 4;
    localparam int DOM  = 20;
    localparam int REC  = 20;
    localparam int WIN  = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus = 1'b0;
    logic standby = 1'b0;
    logic uv = 1'b0;
    logic rxd, wake;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int dbl = 0;
    int r6_viol = 0;
    bit woke = 1'b0;
    bit prev_wake = 1'b0;
    bit done = 1'b0;
    int   exp_q[$];
    string tag_q[$];
    event ev_end;

    always #10 clk = ~clk;

    can_wake_detect #(
        .SYNC_STAGES (2),
        .FILT_CYC    (FILT),
        .DOM_CYC     (DOM),
        .REC_CYC     (REC),
        .WIN_CYC     (WIN)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_dom_i (bus),
        .standby_i (standby),
        .uv_i      (uv),
        .rxd_o     (rxd),
        .wake_o    (wake)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drv(input logic lvl, input int n);
        bus = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic start_scn();
        standby = 1'b0;
        uv = 1'b0;
        bus = 1'b0;
        repeat (5) @(negedge clk);
        standby = 1'b1;
        repeat (20) @(negedge clk);
        pulses = 0;
        dbl = 0;
        r6_viol = 0;
        woke = 1'b0;
    endtask

    task automatic end_scn(input int exp, input string tag);
        drv(1'b0, 200);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ->ev_end;
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (wake) begin
                pulses++;
                woke = 1'b1;
                if (prev_wake) dbl++;
            end
            prev_wake = wake;
            if (standby && !woke && rxd == 1'b0) r6_viol++;
        end
    end

    initial begin
        forever begin
            int e;
            string t;
            @(ev_end);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(pulses == e, t, pulses, e);
            chk(dbl == 0, "R2 pulse width", dbl, 0);
            chk(r6_viol == 0, "R6 rxd high before wake", r6_viol, 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rxd == 1'b1, "R1 rxd in reset", rxd, 1);
        chk(wake == 1'b0, "R1 wake in reset", wake, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rxd == 1'b1, "R1 rxd after reset", rxd, 1);
        chk(wake == 1'b0, "R1 wake after reset", wake, 0);

        // R2 clean pattern, then R7/R8 tracking after wake
        start_scn();
        drv(1'b1, 20); drv(1'b0, 20); drv(1'b1, 20);
        drv(1'b0, 30);
        chk(rxd == 1'b1, "R7 rxd recessive after wake", rxd, 1);
        drv(1'b1, 30);
        chk(rxd == 1'b0, "R7 rxd dominant after wake", rxd, 0);
        begin
            int highs = 0;
            drv(1'b0, 2);
            bus = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (rxd) highs++;
            end
            chk(highs == 0, "R8 spike hidden from rxd", highs, 0);
        end
        end_scn(1, "R2 clean pattern");

        // R3 short first dominant
        start_scn();
        drv(1'b1, 19); drv(1'b0, 30); drv(1'b1, 19);
        end_scn(0, "R3 short dominant");

        // R3 short recessive
        start_scn();
        drv(1'b1, 20); drv(1'b0, 19); drv(1'b1, 20);
        end_scn(0, "R3 short recessive");

        // R4 short intervals in recessive search
        start_scn();
        drv(1'b1, 20); drv(1'b0, 8); drv(1'b1, 8); drv(1'b0, 20); drv(1'b1, 20);
        end_scn(1, "R4 short gap before recessive");

        // R4 short intervals in final dominant search
        start_scn();
        drv(1'b1, 20); drv(1'b0, 20); drv(1'b1, 8); drv(1'b0, 8); drv(1'b1, 20);
        end_scn(1, "R4 short gap before last dominant");

        // R5 completes at the window limit
        start_scn();
        drv(1'b1, 110); drv(1'b0, 20); drv(1'b1, 20);
        end_scn(1, "R5 at window limit");

        // R5 one cycle past
        start_scn();
        drv(1'b1, 111); drv(1'b0, 20); drv(1'b1, 20);
        end_scn(0, "R5 past window");

        // R8 only sub-filter spikes, and a filtered-out spike inside dominant
        start_scn();
        for (int i = 0; i < 40; i++) begin
            drv(1'b1, 3); drv(1'b0, 3);
        end
        end_scn(0, "R8 spike train");

        start_scn();
        drv(1'b1, 10); drv(1'b0, 2); drv(1'b1, 10); drv(1'b0, 20); drv(1'b1, 20);
        end_scn(1, "R8 R12 spike bridged");

        // R9 standby released mid pattern
        start_scn();
        drv(1'b1, 20); drv(1'b0, 10);
        standby = 1'b0;
        drv(1'b0, 4);
        standby = 1'b1;
        drv(1'b0, 10); drv(1'b1, 20);
        end_scn(0, "R9 normal mode abort");

        // R10 undervoltage mid pattern
        start_scn();
        drv(1'b1, 20); drv(1'b0, 10);
        uv = 1'b1;
        drv(1'b0, 4);
        uv = 1'b0;
        drv(1'b0, 10); drv(1'b1, 20);
        end_scn(0, "R10 undervoltage abort");

        // R11 leaving standby clears wake
        start_scn();
        drv(1'b1, 20); drv(1'b0, 20); drv(1'b1, 20);
        drv(1'b0, 20);
        standby = 1'b0;
        drv(1'b0, 5);
        standby = 1'b1;
        drv(1'b1, 15);
        chk(rxd == 1'b1, "R11 rxd high after re-entry", rxd, 1);
        chk(pulses == 1, "R11 no wake on re-entry", pulses, 1);
        drv(1'b0, 30);
        drv(1'b1, 20); drv(1'b0, 20); drv(1'b1, 20);
        end_scn(2, "R11 fresh pattern wakes again");

        done = 1'b1;
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule